// File: doc/BRIEF.md
# fp16 Reciprocal Seed Generator

This block turns one IEEE half-precision operand into a coarse half-precision estimate of its reciprocal, good to about seven bits. A Newton-Raphson kernel elsewhere refines that estimate to full precision. The estimate comes from a 128-entry table of 8-bit reciprocal values. The table is indexed by the seven most significant fraction bits of the normalized operand. The exponent is mirrored around the bias, and the sign is carried across unchanged.

There is no interpolation, so inputs whose reciprocal is exact still carry the table error; 2.0, for example, yields 0.498. Zeros, infinities, NaNs and subnormals each take their own path. Subnormal operands are normalized with a leading-zero count rather than flushed. Results too small for a normal encoding become subnormals by truncating shift, and results too large saturate to infinity.

By default the result is registered: `res_vld` follows `op_vld` by one clock. A parameter removes the register and leaves a purely combinational path.

Top module: `hrs_recip_seed`

## Requirements
- R1: After reset, `res_vld` is 0 and `res_val` is 0x0000. With the default output register, every operand presented with `op_vld` high produces its result one clock later with `res_vld` high, and `res_vld` is low in the cycle after an idle cycle.
- R2: Table entry i equals round(65536 / (257 + 2i)), with a floor of 0x81. This gives 0xFF at index 0, 0xAA at index 64 and 0x81 at index 127. The inputs 0x3C00, 0x3E00 and 0x3FF8 therefore give 0x3BF8, 0x3950 and 0x3808.
- R3: For a normal operand, the table index is fraction bits [9:3]. All eight fractions sharing those bits give the same result.
- R4: For a normal result, the 10-bit fraction field is (entry & 0x7F) << 3, so result bits [2:0] are always 0.
- R5: For an operand exponent field e in 1..28, the result exponent field is 29 − e. Examples: 0x4000 → 0x37F8, 0x3800 → 0x3FF8, 0x0400 → 0x73F8.
- R6: For e = 29 or 30, the 11-bit significand {1, entry[6:0], 000} is shifted right by e − 28 with truncation and placed in a subnormal result. Examples: 0x7BFF → 0x0102, 0x7400 → 0x03FC, 0x7800 → 0x01FE.
- R7: A zero operand gives infinity of the same sign: 0x0000 → 0x7C00, 0x8000 → 0xFC00.
- R8: An infinite operand gives zero of the same sign: 0x7C00 → 0x0000, 0xFC00 → 0x8000.
- R9: A NaN operand gives {sign, 11111, entry, 00}, with the entry indexed by fraction bits [9:3]. The quiet bit (bit 9) is therefore always set. Examples: 0x7E00 → 0x7EA8, 0xFC01 → 0xFFFC, 0x7FFF → 0x7E04.
- R10: A subnormal operand with z leading zeros in its 10-bit fraction is normalized before indexing, and its result exponent field is 29 + z. When 29 + z reaches 31 or more, the result saturates to signed infinity. Examples: 0x03FF → 0x7408, 0x0200 → 0x77F8, 0x0100 → 0x7BF8, 0x00FF → 0x7C00, 0x0001 → 0x7C00, 0x8001 → 0xFC00.
- R11: The result sign bit always equals the operand sign bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_vld | input | 1 | Operand strobe |
| op_val | input | 16 | Half-precision operand |
| res_vld | output | 1 | Result strobe |
| res_val | output | 16 | Half-precision reciprocal seed |

## Verification
Two full sweeps cover all 1024 fractions, one in the exponent-15 binade and one in a negative exponent-16 binade. Each result is compared against a table the bench builds with real arithmetic. The sweeps separate a wrong index slice or a wrong table entry (R2, R3, R4) from an exponent or sign error (R5, R11).

Subnormal operands with zero, one and two leading zeros separate a correct normalization from an off-by-one in the leading-zero count or the saturation threshold (R10). Operands in the top two binades show whether the truncating shift into a subnormal result is handled (R6). Signed zeros, infinities and NaNs with different fractions separate each special path and show that the NaN payload is derived from the table (R7, R8, R9).

// File: rtl/hrs_pkg.sv
package hrs_pkg;

   localparam int unsigned HALF_EXP_W = 5;
   localparam int unsigned HALF_MAN_W = 10;

   typedef enum logic [1:0] {
      K_FINITE = 2'd0,
      K_ZERO   = 2'd1,
      K_INF    = 2'd2,
      K_NAN    = 2'd3
   } kind_e;

   // Reciprocal of the bucket centre, rounded, expressed as an sw-bit fraction.
   // 2^sw / (1 + (2i+1)/2^(iw+1))  ==  2^(sw+iw+1) / (2^(iw+1) + 2i + 1)
   function automatic int unsigned seed_entry(int unsigned i, int unsigned iw, int unsigned sw);
      int unsigned num, den, q, lo, hi;
      num = 32'd1 << (sw + iw + 1);
      den = (32'd1 << (iw + 1)) + 2 * i + 1;
      q   = (2 * num + den) / (2 * den);
      lo  = (32'd1 << (sw - 1)) + 1;
      hi  = (32'd1 << sw) - 1;
      if (q < lo) q = lo;
      if (q > hi) q = hi;
      return q;
   endfunction

endpackage

// File: rtl/hrs_seed_rom.sv
module hrs_seed_rom #(
   parameter int unsigned IDX_W  = 7,
   parameter int unsigned SEED_W = 8
) (
   input  logic [IDX_W-1:0]  idx,
   output logic [SEED_W-1:0] seed
);
   localparam int unsigned DEPTH = 1 << IDX_W;

   logic [SEED_W-1:0] rom [DEPTH];

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
      assign rom[gi] = SEED_W'(hrs_pkg::seed_entry(gi, IDX_W, SEED_W));
   end

   assign seed = rom[idx];

endmodule

// File: rtl/hrs_unpack.sv
module hrs_unpack #(
   parameter int unsigned EXP_W = hrs_pkg::HALF_EXP_W,
   parameter int unsigned MAN_W = hrs_pkg::HALF_MAN_W,
   parameter int unsigned IDX_W = 7,
   localparam int unsigned W    = 1 + EXP_W + MAN_W,
   localparam int unsigned EW   = EXP_W + 3,
   localparam int unsigned LZ_W = $clog2(MAN_W + 1)
) (
   input  logic                 [W-1:0]     x,
   output logic                             sign,
   output hrs_pkg::kind_e                   kind,
   output logic signed          [EW-1:0]    eff_exp,
   output logic                 [IDX_W-1:0] idx
);
   localparam logic [EXP_W-1:0] EXP_ONES = '1;

   logic [EXP_W-1:0] e;
   logic [MAN_W-1:0] m;
   logic [LZ_W-1:0]  lz;
   logic             found;
   int unsigned      sh;

   assign sign = x[W-1];
   assign e    = x[W-2 -: EXP_W];
   assign m    = x[MAN_W-1:0];

   // leading-zero count over the fraction field
   always_comb begin
      lz    = '0;
      found = 1'b0;
      for (int k = MAN_W - 1; k >= 0; k--) begin
         if (!found) begin
            if (m[k]) found = 1'b1;
            else      lz    = lz + 1'b1;
         end
      end
   end

   always_comb begin
      sh      = int'(lz) + 1;
      kind    = hrs_pkg::K_FINITE;
      eff_exp = $signed(EW'(e));
      idx     = m[MAN_W-1 -: IDX_W];
      if (e == EXP_ONES) begin
         kind = (m == '0) ? hrs_pkg::K_INF : hrs_pkg::K_NAN;
      end else if (e == '0) begin
         if (m == '0) begin
            kind = hrs_pkg::K_ZERO;
         end else begin
            // shift the leading one out; its weight becomes exponent -lz
            eff_exp = -$signed(EW'(lz));
            idx     = IDX_W'((MAN_W'(m << sh)) >> (MAN_W - IDX_W));
         end
      end
   end

endmodule

// File: rtl/hrs_pack.sv
module hrs_pack #(
   parameter int unsigned EXP_W  = hrs_pkg::HALF_EXP_W,
   parameter int unsigned MAN_W  = hrs_pkg::HALF_MAN_W,
   parameter int unsigned SEED_W = 8,
   localparam int unsigned W     = 1 + EXP_W + MAN_W,
   localparam int unsigned EW    = EXP_W + 3
) (
   input  logic                        sign,
   input  hrs_pkg::kind_e              kind,
   input  logic signed [EW-1:0]        eff_exp,
   input  logic        [SEED_W-1:0]    seed,
   output logic        [W-1:0]         y
);
   localparam int          BIAS    = (1 << (EXP_W - 1)) - 1;
   localparam int          MIRROR  = 2 * BIAS - 1;
   localparam int          EXP_TOP = (1 << EXP_W) - 1;
   localparam int unsigned PAD     = MAN_W - (SEED_W - 1);
   localparam int unsigned NAN_PAD = MAN_W - SEED_W;
   localparam logic [EXP_W-1:0] EXP_ONES = '1;

   logic [MAN_W:0]   sig;
   logic [MAN_W:0]   sub;
   logic [MAN_W-1:0] nan_frac;
   int               eo;
   int               sh;

   assign sig      = {1'b1, seed[SEED_W-2:0], {PAD{1'b0}}};
   assign nan_frac = {seed, {NAN_PAD{1'b0}}};

   always_comb begin
      eo  = MIRROR - int'(eff_exp);
      sh  = 1 - eo;
      sub = sig >> sh;
      unique case (kind)
         hrs_pkg::K_ZERO: y = {sign, EXP_ONES, {MAN_W{1'b0}}};
         hrs_pkg::K_INF:  y = {sign, {EXP_W{1'b0}}, {MAN_W{1'b0}}};
         hrs_pkg::K_NAN:  y = {sign, EXP_ONES, nan_frac};
         default: begin
            if (eo >= EXP_TOP)  y = {sign, EXP_ONES, {MAN_W{1'b0}}};
            else if (eo >= 1)   y = {sign, eo[EXP_W-1:0], sig[MAN_W-1:0]};
            else                y = {sign, {EXP_W{1'b0}}, sub[MAN_W-1:0]};
         end
      endcase
   end

endmodule

// File: rtl/hrs_recip_seed.sv
module hrs_recip_seed #(
   parameter int unsigned EXP_W   = hrs_pkg::HALF_EXP_W,
   parameter int unsigned MAN_W   = hrs_pkg::HALF_MAN_W,
   parameter int unsigned IDX_W   = 7,
   parameter int unsigned SEED_W  = 8,
   parameter bit          OUT_REG = 1'b1,
   localparam int unsigned W      = 1 + EXP_W + MAN_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         op_vld,
   input  logic [W-1:0] op_val,
   output logic         res_vld,
   output logic [W-1:0] res_val
);
   localparam int unsigned EW     = EXP_W + 3;
   localparam int          BIAS   = (1 << (EXP_W - 1)) - 1;
   localparam int          MIRROR = 2 * BIAS - 1;

   if (SEED_W != IDX_W + 1) begin : g_chk_seed
      $error("SEED_W must be IDX_W+1");
   end
   if (IDX_W > MAN_W || SEED_W > MAN_W) begin : g_chk_idx
      $error("index and seed must fit the fraction field");
   end
   if (EXP_W < 3) begin : g_chk_exp
      $error("EXP_W too small");
   end

   logic                  op_sign;
   hrs_pkg::kind_e        op_kind;
   logic signed [EW-1:0]  op_exp;
   logic [IDX_W-1:0]      rom_idx;
   logic [SEED_W-1:0]     rom_seed;
   logic [W-1:0]          seed_word;

   hrs_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W), .IDX_W(IDX_W)) u_unpack (
      .x       (op_val),
      .sign    (op_sign),
      .kind    (op_kind),
      .eff_exp (op_exp),
      .idx     (rom_idx)
   );

   hrs_seed_rom #(.IDX_W(IDX_W), .SEED_W(SEED_W)) u_rom (
      .idx  (rom_idx),
      .seed (rom_seed)
   );

   hrs_pack #(.EXP_W(EXP_W), .MAN_W(MAN_W), .SEED_W(SEED_W)) u_pack (
      .sign    (op_sign),
      .kind    (op_kind),
      .eff_exp (op_exp),
      .seed    (rom_seed),
      .y       (seed_word)
   );

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            res_vld <= 1'b0;
            res_val <= '0;
         end else begin
            res_vld <= op_vld;
            if (op_vld) res_val <= seed_word;
         end
      end

      // R1: strobe follows the operand strobe by one clock
      a_r1_vld_latency: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> res_vld == $past(op_vld));
      // R7: zero operand -> signed infinity
      a_r7_zero_to_inf: assert property (@(posedge clk) disable iff (!rst_n)
         (op_vld && op_val[W-2:0] == '0) |=>
         res_val == {$past(op_val[W-1]), {EXP_W{1'b1}}, {MAN_W{1'b0}}});
      // R8: infinite operand -> signed zero
      a_r8_inf_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (op_vld && op_val[W-2 -: EXP_W] == '1 && op_val[MAN_W-1:0] == '0) |=>
         res_val == {$past(op_val[W-1]), {(W-1){1'b0}}});
      // R9: NaN operand -> quiet NaN
      a_r9_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         (op_vld && op_val[W-2 -: EXP_W] == '1 && op_val[MAN_W-1:0] != '0) |=>
         (res_val[W-2 -: EXP_W] == '1 && res_val[MAN_W-1]));
      // R5: normal operand in the mirrored range -> exponent 29 - e
      a_r5_exp_mirror: assert property (@(posedge clk) disable iff (!rst_n)
         (op_vld && op_val[W-2 -: EXP_W] != '0 &&
          int'(op_val[W-2 -: EXP_W]) < MIRROR) |=>
         int'(res_val[W-2 -: EXP_W]) == MIRROR - int'($past(op_val[W-2 -: EXP_W])));
      // R11: sign is carried through on every result
      a_r11_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
         op_vld |=> res_val[W-1] == $past(op_val[W-1]));
   end else begin : g_comb
      assign res_vld = op_vld;
      assign res_val = seed_word;

      a_r11_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
         op_vld |-> res_val[W-1] == op_val[W-1]);
      a_r7_zero_to_inf: assert property (@(posedge clk) disable iff (!rst_n)
         (op_vld && op_val[W-2:0] == '0) |-> res_val[W-2:0] == {{EXP_W{1'b1}}, {MAN_W{1'b0}}});
      a_r8_inf_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (op_vld && op_val[W-2 -: EXP_W] == '1 && op_val[MAN_W-1:0] == '0) |->
         res_val[W-2:0] == '0);
      a_r9_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         (op_vld && op_val[W-2 -: EXP_W] == '1 && op_val[MAN_W-1:0] != '0) |->
         (res_val[W-2 -: EXP_W] == '1 && res_val[MAN_W-1]));
   end

endmodule

// File: tb/hrs_recip_seed_tb.sv
`timescale 1ns/1ps
module hrs_recip_seed_tb;

   typedef struct {
      logic [15:0] x;
      logic [15:0] exp_val;
      string       tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_vld = 1'b0;
   logic [15:0] op_val = '0;
   logic        res_vld;
   logic [15:0] res_val;

   int    n_checks = 0;
   int    n_fail = 0;
   bit    finished = 1'b0;
   item_t sb[$];

   always #2.5 clk = ~clk;

   hrs_recip_seed u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .op_vld  (op_vld),
      .op_val  (op_val),
      .res_vld (res_vld),
      .res_val (res_val)
   );

   // bench-side table: reciprocal of the bucket centre, real arithmetic
   function automatic int tb_entry(int i);
      real v;
      int  b;
      v = 256.0 / (1.0 + (real'(i) + 0.5) / 128.0);
      b = $rtoi(v + 0.5);
      if (b < 129) b = 129;
      return b;
   endfunction

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] expv);
      n_checks++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, expv);
      end
   endtask

   task automatic send(input logic [15:0] x, input logic [15:0] expv, input string tag);
      item_t it;
      @(negedge clk);
      op_vld = 1'b1;
      op_val = x;
      it.x = x; it.exp_val = expv; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic idle();
      @(negedge clk);
      op_vld = 1'b0;
      op_val = 16'hDEAD;
   endtask

   // monitor: pops the scoreboard whenever a result is flagged
   always @(posedge clk) begin
      #1;
      if (rst_n && res_vld) begin
         if (sb.size() == 0) begin
            n_checks++; n_fail++;
            $display("FAIL R1 unexpected result actual=0x%04h expected=none", res_val);
         end else begin
            item_t it;
            it = sb.pop_front();
            check($sformatf("%s in=0x%04h", it.tag, it.x), res_val, it.exp_val);
         end
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset vld", {15'b0, res_vld}, 16'h0000);
      check("R1 reset val", res_val, 16'h0000);
      @(negedge clk);
      rst_n = 1'b1;

      // R2 table anchor points, R5 exponent mirror
      send(16'h3C00, 16'h3BF8, "R2 idx0");
      send(16'h3E00, 16'h3950, "R2 idx64");
      send(16'h3FF8, 16'h3808, "R2 idx127");
      send(16'h4000, 16'h37F8, "R5 two");
      send(16'h3800, 16'h3FF8, "R5 half");
      send(16'h0400, 16'h73F8, "R5 min normal");
      idle();
      @(posedge clk); #1;
      check("R1 idle vld low", {15'b0, res_vld}, 16'h0000);

      // R6 top binades
      send(16'h7BFF, 16'h0102, "R6 max finite");
      send(16'h7400, 16'h03FC, "R6 e29");
      send(16'h7800, 16'h01FE, "R6 e30");
      send(16'hFBFF, 16'h8102, "R6 R11 neg max");
      // R7 R8 zeros and infinities
      send(16'h0000, 16'h7C00, "R7 +0");
      send(16'h8000, 16'hFC00, "R7 -0");
      send(16'h7C00, 16'h0000, "R8 +inf");
      send(16'hFC00, 16'h8000, "R8 -inf");
      // R9 NaNs
      send(16'h7E00, 16'h7EA8, "R9 qnan");
      send(16'hFC01, 16'hFFFC, "R9 snan neg");
      send(16'h7FFF, 16'h7E04, "R9 nan top");
      // R10 subnormals
      send(16'h03FF, 16'h7408, "R10 lz0 max");
      send(16'h0200, 16'h77F8, "R10 lz0");
      send(16'h0100, 16'h7BF8, "R10 lz1");
      send(16'h00FF, 16'h7C00, "R10 lz2 sat");
      send(16'h0001, 16'h7C00, "R10 min sub");
      send(16'h8001, 16'hFC00, "R10 R11 neg sub");
      idle();

      // R3 R4 sweep: exponent 15, every fraction
      for (int m = 0; m < 1024; m++) begin
         logic [15:0] e;
         e = 16'h3800 | 16'((tb_entry(m >> 3) & 8'h7F) << 3);
         send(16'h3C00 | 16'(m), e, "R3 R4 sweep e15");
      end
      idle();
      // R5 R11 sweep: negative, exponent 16
      for (int m = 0; m < 1024; m++) begin
         logic [15:0] e;
         e = 16'h8000 | 16'h3400 | 16'((tb_entry(m >> 3) & 8'h7F) << 3);
         send(16'hC000 | 16'(m), e, "R5 R11 sweep e16");
      end
      idle();
      repeat (4) @(negedge clk);
      check("R1 scoreboard drained", 16'(sb.size()), 16'h0000);
      finish_run();
   end

endmodule